// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps 32-bit internal bus addresses that land in a fixed outbound window onto 64-bit link addresses. The window spans 0x6000_0000 through 0x6FFF_FFFF and is divided into 32 regions. A programmable region size of 1, 2, 4 or 8 MB decides which internal address bits pick the region. Each region has its own offset registers, and the chosen region's offset replaces the upper bits of the address. The low-order bits always pass straight through from the internal address.

Software programs the block through a small word-addressed register port. One control word holds the global translate enable and the size select. Each region has two words: an offset-low word, which carries the offset bits and the region enable, and an offset-high word, which supplies the top 32 link address bits. The datapath takes an address with a valid strobe. One cycle later it returns the translated address, a hit flag, and an error flag. The error flag is raised for a disabled region or for an address outside the window.

Top module: `obwin_xlate`

## Requirements
- R1: With translation enabled, an address whose bits [31:28] are not 0x6 gives out_err=1 and out_hit=0, and out_addr is {32'h0, address}.
- R2: Control word (reg_addr 0) bits [2:1] select the region size: 0=1 MB, 1=2 MB, 2=4 MB, 3=8 MB. The region index is taken from address bits [24:20], [25:21], [26:22] or [27:23] respectively. Window bits above the index field are ignored.
- R3: On a hit, out_addr[31:0] is built from two parts: offset-low bits from 20+size upward, and the address bits below 20+size. out_addr[63:32] is the region's offset-high word.
- R4: The offset-low word of region n is at reg_addr 64+2n and the offset-high word at 65+2n. The offset-low word keeps only bits [31:20] (offset) and bit 0 (region enable). Writes to its other bits are ignored, and those bits read back as zero.
- R5: With translation enabled, an in-window address that selects a region whose enable bit is 0 gives out_err=1 and out_hit=0, and out_addr is {32'h0, address}.
- R6: When control bit 0 is 0, out_addr is {32'h0, address}, and out_hit=0 and out_err=0 for any address.
- R7: out_valid is high exactly in the cycle after in_valid is high. Results are registered once.
- R8: A register write affects only translations presented in later cycles. A translation presented in the same cycle as a write uses the old value.
- R9: After reset, out_valid, out_hit and out_err are 0, and all register words read as zero.
- R10: out_hit and out_err are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word address (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| in_valid | input | 1 | Internal address valid |
| in_addr | input | 32 | Internal address |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_addr | output | 64 | Translated or passed-through address |
| out_hit | output | 1 | Address translated through an enabled region |
| out_err | output | 1 | Address outside the window or region disabled |

## Verification
The hardest case to reach is a register write and a translation that land in the same clock cycle. Only then does the ordering of the register update against the output capture show at the ports. The bench drives the write strobe and the valid strobe on the same falling edge. It checks that the result carries the old offset, then repeats the translation and checks for the new one. Aliasing across the four size settings is also easy to miss. The vector table therefore reprograms the size before each vector and includes addresses whose upper window bits fall outside the index field.

// File: rtl/obwin_pkg.sv
// Package: shared constants and result type for the outbound window translator.
// Assumes a 32-bit internal bus and a 64-bit link address.
package obwin_pkg;
    localparam int ADDR_W      = 32;
    localparam int LINK_W      = 64;
    localparam int NUM_REGIONS = 32;
    localparam int SEL_W       = 2;
    localparam int MIN_LSB     = 20;   // bit position of the smallest region size (1 MB)
    localparam logic [3:0] WIN_TAG = 4'h6;  // address bits [31:28] of the window

    typedef struct packed {
        logic              hit;
        logic              err;
        logic [LINK_W-1:0] addr;
    } xlate_res_t;
endpackage

// File: rtl/obwin_regs.sv
// Register file: control word plus per-region offset-low and offset-high words.
// Assumes word addressing; region words start at half of the address space.
module obwin_regs
    import obwin_pkg::*;
#(
    parameter int NR     = NUM_REGIONS,
    parameter int REG_AW = $clog2(NUM_REGIONS) + 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [REG_AW-1:0]           addr,
    input  logic [ADDR_W-1:0]           wdata,
    output logic [ADDR_W-1:0]           rdata,
    output logic                        xlate_en,
    output logic [SEL_W-1:0]            size_sel,
    output logic [NR-1:0][ADDR_W-MIN_LSB-1:0] off_lo,
    output logic [NR-1:0]               reg_en,
    output logic [NR-1:0][ADDR_W-1:0]   off_hi
);
    localparam int IDX_W = $clog2(NR);
    localparam int OFF_W = ADDR_W - MIN_LSB;

    logic            region_sel;
    logic [IDX_W-1:0] widx;

    assign region_sel = addr[REG_AW-1];
    assign widx       = addr[IDX_W:1];

    // Control word: enable in bit 0, size select above it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xlate_en <= 1'b0;
            size_sel <= '0;
        end else if (wr && !region_sel && addr == '0) begin
            xlate_en <= wdata[0];
            size_sel <= wdata[SEL_W:1];
        end
    end

    for (genvar g = 0; g < NR; g++) begin : g_region
        // Per-region storage; reserved offset-low bits are never stored.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                off_lo[g] <= '0;
                reg_en[g] <= 1'b0;
                off_hi[g] <= '0;
            end else if (wr && region_sel && widx == IDX_W'(g)) begin
                if (addr[0]) begin
                    off_hi[g] <= wdata;
                end else begin
                    off_lo[g] <= wdata[ADDR_W-1:MIN_LSB];
                    reg_en[g] <= wdata[0];
                end
            end
        end
    end

    // Read mux: stored value with reserved bits zero.
    always_comb begin
        rdata = '0;
        if (region_sel) begin
            if (addr[0]) rdata = off_hi[widx];
            else         rdata = {off_lo[widx], {(MIN_LSB-1){1'b0}}, reg_en[widx]};
        end else if (addr == '0) begin
            rdata = {{(ADDR_W-SEL_W-1){1'b0}}, size_sel, xlate_en};
        end
    end
endmodule

// File: rtl/obwin_lookup.sv
// Lookup: region decode, window check and address merge, purely combinational.
// Assumes the window occupies one 256 MB slot tagged by bits [31:28].
module obwin_lookup
    import obwin_pkg::*;
#(
    parameter int NR = NUM_REGIONS
) (
    input  logic                        xlate_en,
    input  logic [SEL_W-1:0]            size_sel,
    input  logic [NR-1:0][ADDR_W-MIN_LSB-1:0] off_lo,
    input  logic [NR-1:0]               reg_en,
    input  logic [NR-1:0][ADDR_W-1:0]   off_hi,
    input  logic [ADDR_W-1:0]           addr,
    output xlate_res_t                  res
);
    localparam int IDX_W = $clog2(NR);

    logic [5:0]        shift;
    logic [ADDR_W-1:0] low_mask;
    logic [ADDR_W-1:0] shifted;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] off_word;
    logic              in_win;

    // Decode region index and merge mask from the size select.
    always_comb begin
        shift    = 6'(MIN_LSB) + 6'(size_sel);
        low_mask = (ADDR_W'(1) << shift) - ADDR_W'(1);
        shifted  = addr >> shift;
        idx      = shifted[IDX_W-1:0];
        off_word = {off_lo[idx], {MIN_LSB{1'b0}}};
        in_win   = (addr[ADDR_W-1:ADDR_W-4] == WIN_TAG);
    end

    // Produce the result: bypass, error pass-through, or translation.
    always_comb begin
        res.hit  = 1'b0;
        res.err  = 1'b0;
        res.addr = {{(LINK_W-ADDR_W){1'b0}}, addr};
        if (xlate_en) begin
            if (in_win && reg_en[idx]) begin
                res.hit  = 1'b1;
                res.addr = {off_hi[idx], (off_word & ~low_mask) | (addr & low_mask)};
            end else begin
                res.err  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/obwin_xlate.sv
// Top: outbound window translator with one registered output stage.
// Assumes register writes and translations share one clock.
module obwin_xlate
    import obwin_pkg::*;
#(
    parameter int NR     = NUM_REGIONS,
    parameter int REG_AW = $clog2(NUM_REGIONS) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              in_valid,
    input  logic [31:0]       in_addr,
    output logic              out_valid,
    output logic [63:0]       out_addr,
    output logic              out_hit,
    output logic              out_err
);
    logic                               xlate_en;
    logic [SEL_W-1:0]                   size_sel;
    logic [NR-1:0][ADDR_W-MIN_LSB-1:0]  off_lo;
    logic [NR-1:0]                      reg_en;
    logic [NR-1:0][ADDR_W-1:0]          off_hi;
    xlate_res_t                         res;

    obwin_regs #(.NR(NR), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .xlate_en(xlate_en),
        .size_sel(size_sel), .off_lo(off_lo), .reg_en(reg_en), .off_hi(off_hi)
    );

    obwin_lookup #(.NR(NR)) u_lookup (
        .xlate_en(xlate_en), .size_sel(size_sel), .off_lo(off_lo),
        .reg_en(reg_en), .off_hi(off_hi), .addr(in_addr), .res(res)
    );

    // Output stage: capture the lookup result whenever an address is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_err   <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_hit  <= res.hit;
                out_err  <= res.err;
                out_addr <= res.addr;
            end
        end
    end
endmodule

// File: rtl/obwin_checker.sv
// Checker: temporal properties of the translator, bound to the top module.
module obwin_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_addr,
    input logic        xlate_en,
    input logic        out_valid,
    input logic [63:0] out_addr,
    input logic        out_hit,
    input logic        out_err
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                       // R7
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                     // R7
    AST_HIT_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_hit && out_err));                                        // R10
    AST_BYPASS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !xlate_en) |=> (!out_hit && !out_err
                                     && out_addr == {32'h0, $past(in_addr)})); // R6
    AST_OUTSIDE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && xlate_en && in_addr[31:28] != 4'h6) |=> (out_err && !out_hit)); // R1
    AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && xlate_en) |=> (!out_hit || out_addr[19:0] == $past(in_addr[19:0]))); // R3
endmodule

bind obwin_xlate obwin_checker u_obwin_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .xlate_en(xlate_en), .out_valid(out_valid), .out_addr(out_addr),
    .out_hit(out_hit), .out_err(out_err)
);

// File: tb/test_obwin_xlate.sv
module test_obwin_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic [63:0] out_addr;
    logic        out_hit;
    logic        out_err;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    obwin_xlate i_obwin_xlate (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_addr(in_addr), .out_valid(out_valid), .out_addr(out_addr),
        .out_hit(out_hit), .out_err(out_err)
    );

    // {size_sel[2], address[32], hit, err, expected link address[64]}
    localparam int NV = 15;
    localparam logic [99:0] VEC [NV] = '{
        {2'd3, 32'h6000_0000, 1'b1, 1'b0, 64'h0000_0001_8C80_0000},
        {2'd3, 32'h6052_2000, 1'b1, 1'b0, 64'h0000_0001_8CD2_2000},
        {2'd3, 32'h6080_0004, 1'b1, 1'b0, 64'h0000_0000_1200_0004},
        {2'd3, 32'h6280_0000, 1'b0, 1'b1, 64'h0000_0000_6280_0000},
        {2'd3, 32'h6FFF_FFFC, 1'b1, 1'b0, 64'hDEAD_BEEF_FFFF_FFFC},
        {2'd3, 32'h7000_0000, 1'b0, 1'b1, 64'h0000_0000_7000_0000},
        {2'd3, 32'h5FFF_FFFF, 1'b0, 1'b1, 64'h0000_0000_5FFF_FFFF},
        {2'd0, 32'h6010_0ABC, 1'b1, 1'b0, 64'h0000_0000_1230_0ABC},
        {2'd0, 32'h6000_0010, 1'b1, 1'b0, 64'h0000_0001_8CB0_0010},
        {2'd0, 32'h6050_0000, 1'b0, 1'b1, 64'h0000_0000_6050_0000},
        {2'd0, 32'h61F0_0001, 1'b1, 1'b0, 64'hDEAD_BEEF_FFF0_0001},
        {2'd0, 32'h6020_0000, 1'b0, 1'b1, 64'h0000_0000_6020_0000},
        {2'd1, 32'h6020_0123, 1'b1, 1'b0, 64'h0000_0000_1220_0123},
        {2'd2, 32'h6040_0000, 1'b1, 1'b0, 64'h0000_0000_1200_0000},
        {2'd2, 32'h6C00_0000, 1'b0, 1'b1, 64'h0000_0000_6C00_0000}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic xl(input logic [31:0] a);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(!out_valid && !out_hit && !out_err, "R9 flags", {61'h0, out_valid, out_hit, out_err}, 64'h0);
        rst_n = 1'b1;
        rd(7'd0, d);  check(d == 32'h0, "R9 control", {32'h0, d}, 64'h0);
        rd(7'd64, d); check(d == 32'h0, "R9 region0 low", {32'h0, d}, 64'h0);

        // Program regions 0, 1, 5 (disabled), 31.
        wr(7'd64, 32'h8CB2_2001); wr(7'd65, 32'h0000_0001);
        wr(7'd66, 32'h1230_0001); wr(7'd67, 32'h0000_0000);
        wr(7'd74, 32'hABC0_0000);
        wr(7'd126, 32'hFFF0_0001); wr(7'd127, 32'hDEAD_BEEF);

        // R4: reserved bits dropped
        rd(7'd64, d); check(d == 32'h8CB0_0001, "R4 region0 low", {32'h0, d}, 64'h8CB0_0001);
        wr(7'd70, 32'hFFFF_FFFF); rd(7'd70, d);
        check(d == 32'hFFF0_0001, "R4 region3 low", {32'h0, d}, 64'hFFF0_0001);
        wr(7'd70, 32'h0000_0000);
        wr(7'd0, 32'hFFFF_FFF7); rd(7'd0, d);
        check(d == 32'h0000_0007, "R4 control reserved", {32'h0, d}, 64'h7);

        // Table: R1 R2 R3 R5 R10
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  s;
            logic [31:0] a;
            logic        eh, ee;
            logic [63:0] ea;
            {s, a, eh, ee, ea} = VEC[i];
            wr(7'd0, {29'h0, s, 1'b1});
            xl(a);
            check(out_valid && out_hit == eh && out_err == ee && out_addr == ea && !(out_hit && out_err),
                  "R1/R2/R3/R5/R10 vector", out_addr, ea);
        end

        // R7: valid drops in the following cycle
        @(negedge clk);
        check(!out_valid, "R7 valid single cycle", {63'h0, out_valid}, 64'h0);

        // R5: disable region 0 then access it
        wr(7'd0, 32'h7);
        wr(7'd64, 32'h8CB0_0000);
        xl(32'h6000_0100);
        check(out_err && !out_hit, "R5 disabled region", {62'h0, out_hit, out_err}, 64'h1);
        wr(7'd64, 32'h8CB0_0001);

        // R8: write in same cycle as translation uses old offset
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 7'd66; reg_wdata = 32'h4560_0001;
        in_valid = 1'b1; in_addr = 32'h6080_0000;
        @(negedge clk);
        reg_wr = 1'b0; in_valid = 1'b0;
        check(out_addr == 64'h0000_0000_1200_0000, "R8 same cycle old value", out_addr, 64'h1200_0000);
        xl(32'h6080_0000);
        check(out_addr == 64'h0000_0000_4500_0000 && out_hit, "R8 next cycle new value", out_addr, 64'h4500_0000);

        // R6: global disable passes through
        wr(7'd0, 32'h6);
        xl(32'h6000_0000);
        check(out_addr == 64'h6000_0000 && !out_hit && !out_err, "R6 bypass in window", out_addr, 64'h6000_0000);
        xl(32'h7123_4567);
        check(out_addr == 64'h7123_4567 && !out_hit && !out_err, "R6 bypass outside", out_addr, 64'h7123_4567);

        // R9: reset clears registers and flags again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(7'd127, d); check(d == 32'h0, "R9 region31 high after reset", {32'h0, d}, 64'h0);
        check(!out_valid && !out_hit && !out_err && out_addr == 64'h0, "R9 outputs after reset", out_addr, 64'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule